// File: doc/BRIEF.md
# Exception entry controller

This block decides, at an instruction boundary, which pending processor exception is taken next and produces every register update needed to enter its handler. Seven request lines arrive together: reset, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt and fast interrupt. The block drops any interrupt whose mask bit is set in the current status word. From the requests that remain it picks the one with the highest priority.

For the chosen exception the block registers one entry cycle of outputs:
- the new status word, with its mode field, state bit and mask bits forced;
- a copy of the old status word, together with the mode whose saved-status bank it belongs to;
- the return address for the link register;
- the handler vector for the program counter.

The register file, pipeline flushing and the return from a handler belong to other blocks. Those blocks consume the write enables and data.

The vector base, the data and address widths, the link offset, and whether reset waits for an instruction boundary are all parameters.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On entry, saved_wdata equals the status word presented on the sampling cycle, and saved_mode names the target mode whose saved-status bank is written.
- R2: On entry, status_wdata[4:0] holds the target mode: 10011 (supervisor) for reset and software interrupt, 10111 for both aborts, 11011 for undefined, 10010 for IRQ, 10001 for FIQ. User mode is 10000.
- R3: On entry, status_wdata[5] is 0, status_wdata[7] is 1, and bits above 7 are copied unchanged.
- R4: status_wdata[6] is forced to 1 on reset or FIQ entry only. Every other entry keeps its previous value.
- R5: pc_wdata is the vector base plus an offset: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C. Offset 0x14 is never produced.
- R6: Priority, from highest to lowest, is reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R7: An IRQ request is ignored while status bit 7 is 1, and an FIQ request is ignored while status bit 6 is 1. A lower-priority request is then taken instead.
- R8: link_wdata is the current PC plus 4 and link_we is asserted on every entry except reset, which leaves link_we low.
- R9: Non-reset requests are sampled only on a clock edge where insn_boundary is 1; reset is sampled on any edge (default). The status, saved-status and PC write enables pulse together on the cycle after the sampling edge, and stay low when nothing is taken.
- R10: While rst_n is low all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_boundary | input | 1 | Instruction boundary strobe |
| cur_status | input | DATA_W | Current status word |
| cur_pc | input | ADDR_W | Current program counter |
| req_reset | input | 1 | Reset request |
| req_undef | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabort | input | 1 | Prefetch abort request |
| req_dabort | input | 1 | Data abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| status_we | output | 1 | Status word write enable |
| status_wdata | output | DATA_W | New status word |
| saved_we | output | 1 | Saved-status write enable |
| saved_mode | output | 5 | Mode selecting the saved-status bank |
| saved_wdata | output | DATA_W | Value for saved status |
| link_we | output | 1 | Link register write enable |
| link_wdata | output | ADDR_W | Return address |
| pc_we | output | 1 | Program counter write enable |
| pc_wdata | output | ADDR_W | Handler vector |

## Verification
Every result of an entry is due exactly one clock after the edge that samples the requests, status and PC, because a single output register stage lies between them. The bench drives a new input set on each falling edge and updates its behavioural model from those inputs. It compares the outputs on the following falling edge, half a cycle after the register stage updates. Data fields are compared only on cycles where the model expects an entry. Write enables are compared on every cycle, so a missed or spurious pulse shows up in the cycle it happens.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   localparam int unsigned MODE_W    = 5;
   localparam int unsigned NUM_KINDS = 7;
   localparam int unsigned KIND_W    = $clog2(NUM_KINDS);

   localparam int unsigned ST_T_BIT = 5;
   localparam int unsigned ST_F_BIT = 6;
   localparam int unsigned ST_I_BIT = 7;

   localparam logic [MODE_W-1:0] MODE_USER  = 5'b10000;
   localparam logic [MODE_W-1:0] MODE_FIQ   = 5'b10001;
   localparam logic [MODE_W-1:0] MODE_IRQ   = 5'b10010;
   localparam logic [MODE_W-1:0] MODE_SVC   = 5'b10011;
   localparam logic [MODE_W-1:0] MODE_ABORT = 5'b10111;
   localparam logic [MODE_W-1:0] MODE_UNDEF = 5'b11011;

   // Encoding order is the priority order: lower value wins.
   typedef enum logic [KIND_W-1:0] {
      EK_RESET = 3'd0,
      EK_DABT  = 3'd1,
      EK_FIQ   = 3'd2,
      EK_IRQ   = 3'd3,
      EK_PABT  = 3'd4,
      EK_UNDEF = 3'd5,
      EK_SWI   = 3'd6
   } exc_kind_e;

   function automatic logic [MODE_W-1:0] kind_mode(exc_kind_e k);
      case (k)
         EK_RESET: return MODE_SVC;
         EK_DABT:  return MODE_ABORT;
         EK_FIQ:   return MODE_FIQ;
         EK_IRQ:   return MODE_IRQ;
         EK_PABT:  return MODE_ABORT;
         EK_UNDEF: return MODE_UNDEF;
         default:  return MODE_SVC;
      endcase
   endfunction

   // Byte offset of each handler inside the vector table; slot 0x14 unused.
   function automatic logic [4:0] kind_slot(exc_kind_e k);
      case (k)
         EK_RESET: return 5'h00;
         EK_UNDEF: return 5'h04;
         EK_SWI:   return 5'h08;
         EK_PABT:  return 5'h0C;
         EK_DABT:  return 5'h10;
         EK_IRQ:   return 5'h18;
         default:  return 5'h1C;
      endcase
   endfunction

endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
   parameter int unsigned N     = 7,
   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   logic [N:0]   seen;
   logic [N-1:0] gnt;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign gnt[i]    = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (gnt[i]) idx = IDX_W'(i);
      end
   end

   if (N < 2) begin : g_bad_n
      $error("exc_prio_pick: N must be at least 2");
   end

endmodule

// File: rtl/exc_status_former.sv
module exc_status_former
   import exc_entry_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] cur,
   input  exc_kind_e         kind,
   output logic [DATA_W-1:0] nxt
);

   always_comb begin
      nxt                 = cur;
      nxt[MODE_W-1:0]     = kind_mode(kind);
      nxt[ST_T_BIT]       = 1'b0;
      nxt[ST_I_BIT]       = 1'b1;
      if (kind == EK_RESET || kind == EK_FIQ) nxt[ST_F_BIT] = 1'b1;
   end

   if (DATA_W < 8) begin : g_bad_width
      $error("exc_status_former: DATA_W must hold the mask bits");
   end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
   import exc_entry_pkg::*;
#(
   parameter int unsigned        ADDR_W   = 32,
   parameter logic [ADDR_W-1:0]  VEC_BASE = '0
) (
   input  exc_kind_e         kind,
   output logic [ADDR_W-1:0] vec
);

   // Base is 32-byte aligned, so an OR replaces an adder.
   assign vec = VEC_BASE | ADDR_W'(kind_slot(kind));

   if (ADDR_W < 8) begin : g_bad_addr
      $error("exc_vector_gen: ADDR_W too small for the vector table");
   end
   if (VEC_BASE[4:0] != 5'd0) begin : g_bad_base
      $error("exc_vector_gen: VEC_BASE must be 32-byte aligned");
   end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int unsigned       DATA_W               = 32,
   parameter int unsigned       ADDR_W               = 32,
   parameter logic [ADDR_W-1:0] VEC_BASE             = '0,
   parameter int unsigned       LINK_OFFSET          = 4,
   parameter bit                RESET_NEEDS_BOUNDARY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_boundary,
   input  logic [DATA_W-1:0] cur_status,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic              req_reset,
   input  logic              req_undef,
   input  logic              req_swi,
   input  logic              req_pabort,
   input  logic              req_dabort,
   input  logic              req_irq,
   input  logic              req_fiq,
   output logic              status_we,
   output logic [DATA_W-1:0] status_wdata,
   output logic              saved_we,
   output logic [4:0]        saved_mode,
   output logic [DATA_W-1:0] saved_wdata,
   output logic              link_we,
   output logic [ADDR_W-1:0] link_wdata,
   output logic              pc_we,
   output logic [ADDR_W-1:0] pc_wdata
);

   localparam logic [ADDR_W-1:0] LINK_ADD = ADDR_W'(LINK_OFFSET);

   // ---------------- request gating ----------------
   logic rst_take;
   if (RESET_NEEDS_BOUNDARY) begin : g_rst_sync
      assign rst_take = req_reset & insn_boundary;
   end else begin : g_rst_any
      assign rst_take = req_reset;
   end

   logic [NUM_KINDS-1:0] req_vec;
   always_comb begin
      req_vec           = '0;
      req_vec[EK_RESET] = rst_take;
      req_vec[EK_DABT]  = insn_boundary & req_dabort;
      req_vec[EK_FIQ]   = insn_boundary & req_fiq & ~cur_status[ST_F_BIT];
      req_vec[EK_IRQ]   = insn_boundary & req_irq & ~cur_status[ST_I_BIT];
      req_vec[EK_PABT]  = insn_boundary & req_pabort;
      req_vec[EK_UNDEF] = insn_boundary & req_undef;
      req_vec[EK_SWI]   = insn_boundary & req_swi;
   end

   // ---------------- selection and data forming ----------------
   logic              take;
   logic [KIND_W-1:0] win_idx;
   exc_kind_e         win_kind;
   logic [DATA_W-1:0] status_nxt;
   logic [ADDR_W-1:0] vec_nxt;

   exc_prio_pick #(.N(NUM_KINDS)) u_pick (
      .req (req_vec),
      .any (take),
      .idx (win_idx)
   );

   assign win_kind = exc_kind_e'(win_idx);

   exc_status_former #(.DATA_W(DATA_W)) u_status (
      .cur  (cur_status),
      .kind (win_kind),
      .nxt  (status_nxt)
   );

   exc_vector_gen #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_vec (
      .kind (win_kind),
      .vec  (vec_nxt)
   );

   // ---------------- entry register stage ----------------
   logic entry_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         entry_q      <= 1'b0;
         link_we      <= 1'b0;
         status_wdata <= '0;
         saved_wdata  <= '0;
         saved_mode   <= '0;
         link_wdata   <= '0;
         pc_wdata     <= '0;
      end else begin
         entry_q <= take;
         link_we <= take & (win_kind != EK_RESET);
         if (take) begin
            status_wdata <= status_nxt;
            saved_wdata  <= cur_status;
            saved_mode   <= kind_mode(win_kind);
            link_wdata   <= cur_pc + LINK_ADD;
            pc_wdata     <= vec_nxt;
         end
      end
   end

   assign status_we = entry_q;
   assign saved_we  = entry_q;
   assign pc_we     = entry_q;

   // ---------------- assertions ----------------
   assert_saved_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      saved_we |-> saved_wdata == $past(cur_status));

   assert_svc_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_we && pc_wdata == (VEC_BASE + ADDR_W'(8))) |-> saved_mode == MODE_SVC);

   assert_state_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      status_we |-> (!status_wdata[ST_T_BIT] && status_wdata[ST_I_BIT]
                     && status_wdata[DATA_W-1:8] == $past(cur_status[DATA_W-1:8])));

   assert_fiq_mask_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (status_we && pc_wdata != VEC_BASE && pc_wdata != (VEC_BASE + ADDR_W'(28)))
      |-> status_wdata[ST_F_BIT] == $past(cur_status[ST_F_BIT]));

   assert_no_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pc_we |-> pc_wdata != (VEC_BASE + ADDR_W'(20)));

   assert_irq_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_we && pc_wdata == (VEC_BASE + ADDR_W'(24))) |-> !$past(cur_status[ST_I_BIT]));

   assert_link_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> (pc_we && link_wdata == $past(cur_pc) + LINK_ADD));

   assert_reset_no_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_we && pc_wdata == VEC_BASE) |-> !link_we);

   assert_boundary_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!insn_boundary && !req_reset) |=> !pc_we);

endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;

   localparam int DW = 32;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          insn_boundary;
   logic [DW-1:0] cur_status;
   logic [AW-1:0] cur_pc;
   logic          req_reset, req_undef, req_swi, req_pabort;
   logic          req_dabort, req_irq, req_fiq;
   logic          status_we, saved_we, link_we, pc_we;
   logic [DW-1:0] status_wdata, saved_wdata;
   logic [4:0]    saved_mode;
   logic [AW-1:0] link_wdata, pc_wdata;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   exc_entry_ctrl uut (
      .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary),
      .cur_status(cur_status), .cur_pc(cur_pc),
      .req_reset(req_reset), .req_undef(req_undef), .req_swi(req_swi),
      .req_pabort(req_pabort), .req_dabort(req_dabort),
      .req_irq(req_irq), .req_fiq(req_fiq),
      .status_we(status_we), .status_wdata(status_wdata),
      .saved_we(saved_we), .saved_mode(saved_mode), .saved_wdata(saved_wdata),
      .link_we(link_we), .link_wdata(link_wdata),
      .pc_we(pc_we), .pc_wdata(pc_wdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // kinds: 0 reset,1 dabt,2 fiq,3 irq,4 pabt,5 undef,6 swi,-1 none
   function automatic logic [4:0] m_mode(int k);
      case (k)
         0, 6:    return 5'b10011;
         1, 4:    return 5'b10111;
         2:       return 5'b10001;
         3:       return 5'b10010;
         default: return 5'b11011;
      endcase
   endfunction

   function automatic logic [31:0] m_vec(int k);
      int slots[7] = '{0, 16, 28, 24, 12, 4, 8};
      return 32'(slots[k]);
   endfunction

   function automatic int m_pick();
      if (req_reset) return 0;
      if (!insn_boundary) return -1;
      if (req_dabort) return 1;
      if (req_fiq && !cur_status[6]) return 2;
      if (req_irq && !cur_status[7]) return 3;
      if (req_pabort) return 4;
      if (req_undef) return 5;
      if (req_swi) return 6;
      return -1;
   endfunction

   task automatic set_req(input logic [6:0] r);
      {req_swi, req_undef, req_pabort, req_irq, req_fiq, req_dabort, req_reset} = r;
   endtask

   // Called at a falling edge with inputs already driven; checks the next falling edge.
   task automatic step(input string tag);
      int k;
      logic [31:0] st, es, pc;
      k  = m_pick();
      st = cur_status;
      pc = cur_pc;
      es = st;
      if (k >= 0) begin
         es[4:0] = m_mode(k);
         es[5]   = 1'b0;
         es[7]   = 1'b1;
         if (k == 0 || k == 2) es[6] = 1'b1;
      end
      @(negedge clk);
      chk({"R9 status_we ", tag}, 32'(status_we), 32'(k >= 0));
      chk({"R9 saved_we ", tag},  32'(saved_we),  32'(k >= 0));
      chk({"R9 pc_we ", tag},     32'(pc_we),     32'(k >= 0));
      chk({"R8 link_we ", tag},   32'(link_we),   32'(k > 0));
      if (k >= 0) begin
         chk({"R1 saved_wdata ", tag}, saved_wdata, st);
         chk({"R1 saved_mode ", tag}, 32'(saved_mode), 32'(m_mode(k)));
         chk({"R2 mode field ", tag}, 32'(status_wdata[4:0]), 32'(es[4:0]));
         chk({"R3 status bits ", tag}, {status_wdata[31:7], 1'b0, status_wdata[5:0]},
             {es[31:7], 1'b0, es[5:0]});
         chk({"R4 fiq mask ", tag}, 32'(status_wdata[6]), 32'(es[6]));
         chk({"R5 R6 vector ", tag}, pc_wdata, m_vec(k));
         if (k > 0) chk({"R8 link data ", tag}, link_wdata, pc + 32'd4);
      end
   endtask

   task automatic go(input logic [6:0] r, input logic bnd, input logic [31:0] st,
                     input logic [31:0] pc, input string tag);
      set_req(r);
      insn_boundary = bnd;
      cur_status    = st;
      cur_pc        = pc;
      step(tag);
   endtask

   initial begin
      #(20 * 200000);
      failures++;
      checks++;
      $display("FAIL R9 watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] lfsr;
      rst_n = 1'b0;
      insn_boundary = 1'b1;
      cur_status = 32'h0000_0010;
      cur_pc = 32'h0000_1000;
      set_req(7'h7F);
      repeat (3) @(negedge clk);
      // R10: everything cleared while reset held, even with requests pending
      chk("R10 status_we", 32'(status_we), 0);
      chk("R10 pc_we", 32'(pc_we), 0);
      chk("R10 link_we", 32'(link_we), 0);
      chk("R10 pc_wdata", pc_wdata, 0);
      chk("R10 status_wdata", status_wdata, 0);
      chk("R10 saved_wdata", saved_wdata, 0);
      set_req(7'h00);
      rst_n = 1'b1;

      go(7'h00, 1'b1, 32'h0000_0010, 32'h100, "idle");
      // single requests, bit order {swi,undef,pabt,irq,fiq,dabt,reset}
      go(7'h01, 1'b1, 32'hA000_0030, 32'h200, "reset");
      go(7'h02, 1'b1, 32'hA000_0030, 32'h204, "dabt");
      go(7'h04, 1'b1, 32'h5000_0030, 32'h208, "fiq");
      go(7'h08, 1'b1, 32'h5000_0070, 32'h20C, "irq F set R4 keep");
      go(7'h10, 1'b1, 32'h0000_0010, 32'h210, "pabt");
      go(7'h20, 1'b1, 32'h0000_0030, 32'h214, "undef");
      go(7'h40, 1'b1, 32'hF000_0010, 32'h218, "swi R2");
      // boundary gating R9
      go(7'h7E, 1'b0, 32'h0000_0010, 32'h300, "no boundary");
      go(7'h01, 1'b0, 32'h0000_0010, 32'h304, "reset off boundary");
      // priority R6
      go(7'h7F, 1'b1, 32'h0000_0010, 32'h400, "R6 all");
      go(7'h7E, 1'b1, 32'h0000_0010, 32'h404, "R6 dabt over fiq");
      go(7'h7C, 1'b1, 32'h0000_0010, 32'h408, "R6 fiq over irq");
      go(7'h78, 1'b1, 32'h0000_0010, 32'h40C, "R6 irq over pabt");
      go(7'h70, 1'b1, 32'h0000_0010, 32'h410, "R6 pabt over undef");
      go(7'h60, 1'b1, 32'h0000_0010, 32'h414, "R6 undef over swi");
      // masking R7
      go(7'h08, 1'b1, 32'h0000_0090, 32'h500, "R7 irq masked");
      go(7'h18, 1'b1, 32'h0000_0090, 32'h504, "R7 irq masked pabt");
      go(7'h0C, 1'b1, 32'h0000_0050, 32'h508, "R7 fiq masked irq");
      go(7'h04, 1'b1, 32'h0000_00D0, 32'h50C, "R7 both masked");
      go(7'h0C, 1'b1, 32'h0000_00D0, 32'h510, "R7 both masked idle");
      go(7'h01, 1'b1, 32'h0000_00D0, 32'hFFFF_FFFC, "reset masked R8");
      go(7'h02, 1'b1, 32'h0000_0010, 32'hFFFF_FFFC, "R8 link wrap");

      lfsr = 32'h1234_5678;
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         go({lfsr[6:1], lfsr[7] & lfsr[8] & lfsr[9]}, lfsr[10] | lfsr[11],
            {lfsr[31:8], lfsr[15:8]}, {lfsr[23:0], lfsr[31:24]}, "random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule